// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation analog-to-digital converter with four analog inputs. Each clock cycle during a conversion it offers a trial code to an external DAC and reads back one comparator bit. It settles one result bit per cycle, starting at the most significant bit, so one channel takes ten cycles. The finished code goes into that channel's own result register.

Software uses one control register to set the run bit, the operating mode, the channel field, the completion flag, the interrupt enable and the trigger enable. It can read any result register through a select input. In single mode the selected channel is converted once and the run bit then clears itself. In scan mode the channels from 0 up to the selected one are converted in a continuous loop. The completion flag rises at the end of each full pass, and the loop stops only when software clears the run bit. A rising edge on the external trigger input can also set the run bit.

Top module: `adc_seq`

## Requirements
- R1: A conversion takes ten cycles. In each cycle `dac_code` equals the bits kept so far plus the current trial bit, starting at bit 9 and ending at bit 0. When `cmp_in` is 1 (the input is at or above `dac_code`) the trial bit is kept. When it is 0 the trial bit is dropped. The stored result equals the analog level of the input.
- R2: Control write layout: bit 0 run, bit 1 scan mode, bits 3:2 channel, bit 4 done flag, bit 5 interrupt enable, bit 6 trigger enable. Bit 7 is read-only and shows busy. A write with run=1 and scan=0 converts channel `sel` once. After the edge that takes the write, busy is 1 for 11 edges, the result goes into that channel's register, and no other result register changes.
- R3: In single mode the run bit reads 1 during the conversion. It clears on the same edge where the done flag sets and busy falls.
- R4: In scan mode channels 0..sel are converted in ascending order, each into its own register. Done sets on the edge that stores the last channel of the group, which is 31 edges after the start write for a three-channel group. Registers outside the group keep their values.
- R5: In scan mode the run bit stays 1. Conversion of channel 0 restarts on the next cycle, so every later pass ends 30 edges after the one before it.
- R6: A write that clears the run bit during a conversion stops it within one cycle. No result register is written and done does not set.
- R7: Writing 0 to bit 4 clears done. Writing 1 to bit 4 leaves it unchanged. If a set event and a clearing write fall on the same edge, done ends up 1.
- R8: `irq` is high exactly while done and interrupt enable are both 1. It is a level, not a pulse.
- R9: If trigger enable is 1 and the block is idle, a rising edge on `trig_in` sets the run bit. With trigger enable 0 the edge has no effect.
- R10: After reset the control readback, every result register and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback, with busy in bit 7 |
| rd_sel | input | 2 | Result register select |
| rd_data | output | 10 | Selected result register |
| trig_in | input | 1 | External start trigger, synchronous |
| cmp_in | input | 1 | Comparator output: 1 means input >= dac_code |
| dac_code | output | 10 | Trial code for the DAC, 0 while idle |
| mux_ch | output | 2 | Analog multiplexer channel in conversion |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong step counter or a wrong bit decision shows up as a wrong result register value at the end of the ten-cycle conversion. A wrong channel counter in scan mode puts a value into the wrong register, or leaves a register outside the group changed, and this is visible once the pass ends. Errors in run-bit or busy handling show at the exact edge of completion or abort, as a done flag or run bit that differs from its expected value one cycle later. The checks are therefore made at the predicted edge and not by polling.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int RES = 10,
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH),
  localparam int SW = $clog2(RES),
  localparam int CTLW = CW + 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [CTLW-1:0] ctl_wdata,
  output logic [CTLW-1:0] ctl_rdata,
  input  logic [CW-1:0]   rd_sel,
  output logic [RES-1:0]  rd_data,
  input  logic            trig_in,
  input  logic            cmp_in,
  output logic [RES-1:0]  dac_code,
  output logic [CW-1:0]   mux_ch,
  output logic            irq
);
  logic go, scan, done, ie, ten, busy, trig_q;
  logic [CW-1:0]  sel, ch;
  logic [RES-1:0] acc;
  logic [SW-1:0]  step;
  logic [RES-1:0] data [NCH];

  wire [RES-1:0] trial   = acc | (RES'(1) << step);
  wire [RES-1:0] keep    = cmp_in ? trial : acc;
  wire           last    = (step == '0);
  wire           fin     = busy && go && last && (!scan || ch == sel);
  wire           trig_go = ten && trig_in && !trig_q && !busy;
  wire           clr_dn  = ctl_we && !ctl_wdata[CW+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {go, scan, done, ie, ten, busy, trig_q} <= '0;
      sel  <= '0;
      ch   <= '0;
      acc  <= '0;
      step <= '0;
      for (int i = 0; i < NCH; i++) data[i] <= '0;
    end else begin
      trig_q <= trig_in;
      if (ctl_we) begin
        go   <= ctl_wdata[0];
        scan <= ctl_wdata[1];
        sel  <= ctl_wdata[2 +: CW];
        ie   <= ctl_wdata[CW+3];
        ten  <= ctl_wdata[CW+4];
      end else if (trig_go) begin
        go <= 1'b1;
      end else if (fin && !scan) begin
        go <= 1'b0;
      end
      done <= fin | (done & !clr_dn);
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          ch   <= scan ? '0 : sel;
          acc  <= '0;
          step <= SW'(RES - 1);
        end
      end else if (!go) begin
        busy <= 1'b0;
      end else if (!last) begin
        acc  <= keep;
        step <= step - SW'(1);
      end else begin
        data[ch] <= keep;
        acc      <= '0;
        step     <= SW'(RES - 1);
        if (!scan) busy <= 1'b0;
        else       ch   <= (ch == sel) ? '0 : ch + CW'(1);
      end
    end
  end

  assign ctl_rdata = {busy, ten, ie, done, sel, scan, go};
  assign rd_data   = data[rd_sel];
  assign dac_code  = busy ? trial : '0;
  assign mux_ch    = ch;
  assign irq       = done & ie;
endmodule

module adc_seq_chk #(
  parameter int RES = 10,
  parameter int CW = 2,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          scan,
  input logic          busy,
  input logic          done,
  input logic          ie,
  input logic          irq,
  input logic          ctl_we,
  input logic [SW-1:0] step,
  input logic [CW-1:0] ch,
  input logic [CW-1:0] sel
);
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !go |=> !busy);
  // R3
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && !scan && step == '0 && !ctl_we |=> !go && !busy && done);
  // R5
  scan_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && scan && !ctl_we |=> go && busy);
  // R4
  group_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && scan && step == '0 && ch == sel |=> done);
  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step < SW'(RES));
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && ie |-> irq);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind adc_seq adc_seq_chk #(.RES(RES), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .scan(scan), .busy(busy), .done(done),
  .ie(ie), .irq(irq), .ctl_we(ctl_we), .step(step), .ch(ch), .sel(sel)
);

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctl_we = 1'b0, trig_in = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [1:0] rd_sel = '0, mux_ch;
  logic [9:0] rd_data, dac_code;
  logic       cmp_in, irq;
  logic [9:0] ana [4];
  logic [9:0] expd [4];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;
  assign cmp_in = (ana[mux_ch] >= dac_code);

  adc_seq u_dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rd_sel(rd_sel), .rd_data(rd_data), .trig_in(trig_in),
    .cmp_in(cmp_in), .dac_code(dac_code), .mux_ch(mux_ch), .irq(irq));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit go, bit sc, logic [1:0] s, bit dn, bit en, bit te);
    ctl_wdata = {1'b0, te, en, dn, s, sc, go};
    ctl_we = 1'b1;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      check(req, rd_data, expd[i]);
    end
  endtask

  task automatic t_reset;
    check("R10 ctl", ctl_rdata, 0);
    check("R10 irq", irq, 0);
    check_regs("R10 data");
  endtask

  task automatic t_single(logic [1:0] c, logic [9:0] v);
    ana[c] = v;
    wr(1, 0, c, 0, 0, 0);
    tick(10);
    check("R3 busy during", ctl_rdata[7], 1);
    check("R3 go during", ctl_rdata[0], 1);
    check("R2 done early", ctl_rdata[4], 0);
    tick(1);
    check("R2 done", ctl_rdata[4], 1);
    check("R3 go cleared", ctl_rdata[0], 0);
    check("R3 busy cleared", ctl_rdata[7], 0);
    expd[c] = v;
    check_regs("R1 R2 result");
  endtask

  task automatic t_irq;
    check("R8 irq off", irq, 0);
    wr(0, 0, 0, 1, 1, 0);
    check("R7 write1 keeps", ctl_rdata[4], 1);
    check("R8 irq on", irq, 1);
    wr(0, 0, 0, 0, 1, 0);
    check("R7 cleared", ctl_rdata[4], 0);
    check("R8 irq off after clear", irq, 0);
    wr(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_setwins;
    ana[1] = 10'h155;
    wr(1, 0, 2'd1, 0, 0, 0);
    tick(10);
    wr(0, 0, 2'd1, 0, 0, 0);
    check("R7 set wins", ctl_rdata[4], 1);
    expd[1] = 10'h155;
    check_regs("R7 data");
    wr(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_abort;
    ana[3] = 10'h0F0;
    wr(1, 0, 2'd3, 0, 0, 0);
    tick(4);
    wr(0, 0, 2'd3, 0, 0, 0);
    tick(20);
    check("R6 busy", ctl_rdata[7], 0);
    check("R6 done", ctl_rdata[4], 0);
    check_regs("R6 no write");
  endtask

  task automatic t_scan;
    ana[0] = 10'h011; ana[1] = 10'h222; ana[2] = 10'h3A3; ana[3] = 10'h001;
    wr(1, 1, 2'd2, 0, 0, 0);
    tick(30);
    check("R4 done early", ctl_rdata[4], 0);
    tick(1);
    check("R4 done", ctl_rdata[4], 1);
    check("R5 go kept", ctl_rdata[0], 1);
    check("R5 busy kept", ctl_rdata[7], 1);
    expd[0] = 10'h011; expd[1] = 10'h222; expd[2] = 10'h3A3;
    check_regs("R4 pass1");
    ana[0] = 10'h100; ana[1] = 10'h001; ana[2] = 10'h2FF;
    wr(1, 1, 2'd2, 0, 0, 0);
    check("R7 clear in scan", ctl_rdata[4], 0);
    tick(29);
    check("R5 pass2 done", ctl_rdata[4], 1);
    expd[0] = 10'h100; expd[1] = 10'h001; expd[2] = 10'h2FF;
    check_regs("R5 pass2");
    wr(0, 1, 2'd2, 0, 0, 0);
    tick(2);
    check("R6 scan stop", ctl_rdata[7], 0);
  endtask

  task automatic t_trig;
    ana[0] = 10'h05A; ana[1] = 10'h3C3;
    wr(0, 1, 2'd1, 0, 0, 0);
    trig_in = 1'b1; tick(2); trig_in = 1'b0; tick(3);
    check("R9 disabled go", ctl_rdata[0], 0);
    check("R9 disabled busy", ctl_rdata[7], 0);
    wr(0, 1, 2'd1, 0, 0, 1);
    trig_in = 1'b1;
    tick(1);
    check("R9 trig sets go", ctl_rdata[0], 1);
    tick(3); trig_in = 1'b0;
    tick(18);
    check("R9 trig pass done", ctl_rdata[4], 1);
    expd[0] = 10'h05A; expd[1] = 10'h3C3;
    check_regs("R9 trig data");
    wr(0, 1, 2'd1, 0, 0, 0);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ana[i] = '0; expd[i] = '0; end
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_single(2'd2, 10'h2A5);
    t_irq();
    t_single(2'd0, 10'h000);
    t_single(2'd3, 10'h3FF);
    t_setwins();
    t_abort();
    t_scan();
    t_trig();
    finish_run();
  end
endmodule